// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as the clock master of a two-wire synchronous link. It drives the shift clock from a programmable divider and samples a single data input, least significant bit first, at the end of each active clock phase. Each word is 8 bits, or 9 bits when the wide-word mode is selected. The assembled word is held for the host together with a completion flag, an interrupt output and an overrun flag.

Reception is started from a control interface. A one-shot request receives a single word and then stops the clock. A level enable receives words back to back for as long as it stays high. When both are active, the level enable decides whether reception continues. Separate controls invert the driven clock and the sense of the sampled data.

The control machine has three states. `ST_IDLE` holds the clock at its inactive level. `ST_ACT` is the active clock phase, which ends with a sample. `ST_INACT` is the inactive phase between bits and between words. These are its transitions:
- **start**: from idle to active, when reception is allowed.
- **next bit**: from active to inactive, after a bit that is not the last.
- **continue**: from active to inactive, after the last bit while the level enable is high and no overrun occurs.
- **stop**: from active to idle, after the last bit in the other cases.
- **advance**: from inactive to active.
- **abort**: from active or inactive to idle, when permission to receive is withdrawn.

Top module: `sync_master_rx`

## Requirements
- R1: Reception starts only when `port_en` is 1, the single-word request or `cont_en` is active, and `ovr_err` is 0. At all other times `sck` rests at its inactive level, which equals `clk_inv`.
- R2: Each half-period of the shift clock lasts P = N+1 `clk` cycles. N is `div_val[7:0]` when `wide_div` is 0 and the full `div_val[15:0]` when `wide_div` is 1. Every bit starts with the active half-period.
- R3: The data bit is sampled on the last cycle of each active half-period. Bits arrive least significant first.
- R4: A pulse on `single_req` sets `single_busy`. Exactly one word is then received and the clock stops. `single_busy` clears when that word completes.
- R5: While `cont_en` is 1, words are received back to back. Dropping `cont_en` in the middle of a word returns the clock to idle on the next cycle and discards the partial word.
- R6: When `single_req` and `cont_en` are both active, reception continues past the first word.
- R7: With `clk_inv` set to 1, `sck` is the inverted clock, so it idles high. With `dat_inv` set to 1, each bit taken from `sdi` is inverted before it is stored.
- R8: With `nine_bit` set to 1, nine bits are received. Bits 7..0 go to `rx_data` and bit 8 goes to `rx_bit9`. In 8-bit mode, `rx_bit9` is loaded with 0.
- R9: `done_flag` sets in the cycle after the last sample and clears one cycle after `rd_data` is pulsed. `irq` is 1 exactly when `done_flag` and `irq_en` are both 1.
- R10: A word that completes while `done_flag` is 1 and not being read is discarded. In that case `ovr_err` sets, `rx_data` is kept and reception stops. A falling edge of `cont_en` clears `ovr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | Port enabled in synchronous master mode |
| single_req | input | 1 | One-cycle pulse requesting a single word |
| cont_en | input | 1 | Continuous receive enable (level) |
| nine_bit | input | 1 | 1 selects 9-bit words |
| clk_inv | input | 1 | Invert the driven shift clock |
| dat_inv | input | 1 | Invert the sampled data bit |
| wide_div | input | 1 | 1 uses all 16 divider bits, 0 uses the low 8 bits |
| div_val | input | 16 | Divider value N |
| irq_en | input | 1 | Interrupt enable |
| rd_data | input | 1 | One-cycle pulse that reads the received word |
| sdi | input | 1 | Serial data input |
| sck | output | 1 | Shift clock output |
| rx_data | output | 8 | Received word, bits 7..0 |
| rx_bit9 | output | 1 | Ninth received bit |
| done_flag | output | 1 | Received word waiting to be read |
| irq | output | 1 | Receive interrupt |
| ovr_err | output | 1 | Overrun error |
| single_busy | output | 1 | Single-word request pending |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the clock stays idle while the port is disabled or an overrun is pending;
- a word completes only inside an active clock phase;
- the single-word request and the completion flag react to completion and to reads;
- an overrun sets the error flag and leaves the held word untouched.

Only the bench scenarios can show the rest: the assembled bit order, the phase length for each divider width, the inversion controls, and the difference between single, continuous and combined enables. The bench checks these by driving a slave model against every 8-bit value and against a set of 9-bit words.

// File: rtl/sm_rx_pkg.sv
`timescale 1ns/1ps
package sm_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACT   = 2'd1,
        ST_INACT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sm_rx_baud.sv
`timescale 1ns/1ps
// Half-period timer: tick on the last cycle of each clock phase.
module sm_rx_baud #(
    parameter int DIV_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wide,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] cnt;

    always_comb begin
        limit = wide ? div_val : DIV_W'(div_val[NARROW_W-1:0]);
        tick  = run && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sm_rx_fsm.sv
`timescale 1ns/1ps
// Receive control: phase sequencing, bit counting, enable precedence.
module sm_rx_fsm
    import sm_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic single_req,
    input  logic cont_en,
    input  logic nine_bit,
    input  logic ovr_err,
    input  logic ovr_hit,
    input  logic tick,
    output logic run,
    output logic sample,
    output logic word_done,
    output logic sck_active,
    output logic single_busy
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    rx_state_e        state, nxt;
    logic [CNT_W-1:0] bit_idx;
    logic [CNT_W-1:0] last_idx;
    logic             single_q;
    logic             go;
    logic             last_bit;

    always_comb begin
        last_idx = nine_bit ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
        go       = port_en && (cont_en || single_q) && !ovr_err;
        last_bit = (bit_idx == last_idx);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go) nxt = ST_ACT;                      // start
            end
            ST_ACT: begin
                if (!go) begin
                    nxt = ST_IDLE;                         // abort
                end else if (tick) begin
                    if (!last_bit) begin
                        nxt = ST_INACT;                    // next bit
                    end else if (cont_en && !ovr_hit) begin
                        nxt = ST_INACT;                    // continue
                    end else begin
                        nxt = ST_IDLE;                     // stop
                    end
                end
            end
            ST_INACT: begin
                if (!go) begin
                    nxt = ST_IDLE;                         // abort
                end else if (tick) begin
                    nxt = ST_ACT;                          // advance
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run        = (state != ST_IDLE) && go;
        sck_active = (state == ST_ACT);
        sample     = (state == ST_ACT) && go && tick;
        word_done  = sample && last_bit;
        single_busy = single_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (state == ST_IDLE || !go) begin
            bit_idx <= '0;
        end else if (sample) begin
            bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_q <= 1'b0;
        end else if (single_req) begin
            single_q <= 1'b1;
        end else if (word_done) begin
            single_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sm_rx_word.sv
`timescale 1ns/1ps
// Shift register, holding register, completion and overrun flags.
module sm_rx_word #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              din,
    input  logic              word_done,
    input  logic              nine_bit,
    input  logic              rd_data,
    input  logic              cont_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              done_flag,
    output logic              ovr_err
);
    logic [DATA_W:0] sh;
    logic [DATA_W:0] sh_next;
    logic            cont_q;
    logic            collide;

    always_comb begin
        sh_next = {din, sh[DATA_W:1]};
        collide = done_flag && !rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (sample) begin
            sh <= sh_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            done_flag <= 1'b0;
        end else if (word_done && !collide) begin
            rx_data   <= nine_bit ? sh_next[DATA_W-1:0] : sh_next[DATA_W:1];
            rx_bit9   <= nine_bit ? sh_next[DATA_W] : 1'b0;
            done_flag <= 1'b1;
        end else if (rd_data) begin
            done_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q  <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            cont_q <= cont_en;
            if (word_done && collide) begin
                ovr_err <= 1'b1;
            end else if (cont_q && !cont_en) begin
                ovr_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sync_master_rx.sv
`timescale 1ns/1ps
module sync_master_rx #(
    parameter int DIV_W    = 16,
    parameter int NARROW_W = 8,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              single_req,
    input  logic              cont_en,
    input  logic              nine_bit,
    input  logic              clk_inv,
    input  logic              dat_inv,
    input  logic              wide_div,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              irq_en,
    input  logic              rd_data,
    input  logic              sdi,
    output logic              sck,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              done_flag,
    output logic              irq,
    output logic              ovr_err,
    output logic              single_busy
);
    logic run, tick, sample, word_done, sck_active, din, ovr_hit;

    always_comb begin
        din     = sdi ^ dat_inv;
        ovr_hit = done_flag && !rd_data;
        sck     = sck_active ^ clk_inv;
        irq     = done_flag && irq_en;
    end

    sm_rx_baud #(.DIV_W(DIV_W), .NARROW_W(NARROW_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .wide(wide_div),
        .div_val(div_val), .tick(tick)
    );

    sm_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_req(single_req),
        .cont_en(cont_en), .nine_bit(nine_bit), .ovr_err(ovr_err),
        .ovr_hit(ovr_hit), .tick(tick), .run(run), .sample(sample),
        .word_done(word_done), .sck_active(sck_active),
        .single_busy(single_busy)
    );

    sm_rx_word #(.DATA_W(DATA_W)) u_word (
        .clk(clk), .rst_n(rst_n), .sample(sample), .din(din),
        .word_done(word_done), .nine_bit(nine_bit), .rd_data(rd_data),
        .cont_en(cont_en), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .done_flag(done_flag), .ovr_err(ovr_err)
    );
endmodule

// File: rtl/sm_rx_checker.sv
`timescale 1ns/1ps
module sm_rx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              single_req,
    input logic              nine_bit,
    input logic              clk_inv,
    input logic              rd_data,
    input logic              sck,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              done_flag,
    input logic              ovr_err,
    input logic              single_busy,
    input logic              word_done
);
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && $past(!port_en)) |-> (sck == clk_inv));

    a_r3_done_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (sck != clk_inv));

    a_r4_single_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_done && !single_req) |-> !single_busy);

    a_r8_bit9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_done && !nine_bit && !done_flag) |-> !rx_bit9);

    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_done && !done_flag) |-> done_flag);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data && !word_done) |-> !done_flag);

    a_r10_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_done && done_flag && !rd_data) |-> ovr_err);

    a_r10_ovr_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |-> (sck == clk_inv));

    a_r10_ovr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && $past(ovr_err)) |-> $stable(rx_data));
endmodule

bind sync_master_rx sm_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_req(single_req),
    .nine_bit(nine_bit), .clk_inv(clk_inv), .rd_data(rd_data), .sck(sck),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .done_flag(done_flag),
    .ovr_err(ovr_err), .single_busy(single_busy), .word_done(word_done)
);

// File: tb/sync_master_rx_bench.sv
`timescale 1ns/1ps
module sync_master_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0, single_req = 1'b0, cont_en = 1'b0;
    logic        nine_bit = 1'b0, clk_inv = 1'b0, dat_inv = 1'b0;
    logic        wide_div = 1'b0, irq_en = 1'b0, rd_data = 1'b0, sdi = 1'b0;
    logic [15:0] div_val = 16'd0;
    logic        sck, rx_bit9, done_flag, irq, ovr_err, single_busy;
    logic [7:0]  rx_data;

    int n_tests = 0;
    int n_fail  = 0;

    // slave model state
    logic sl_clear = 1'b0;
    logic sl_comp  = 1'b1;
    int   sl_base  = 0;
    int   sl_step  = 1;
    int   sl_bit   = 0;
    int   sl_word  = 0;
    int   hi_len   = 0;
    int   last_hi  = 0;
    logic sck_prev = 1'b0;
    logic sck_eff;

    always #2.5 clk = ~clk;

    sync_master_rx u_sync_master_rx (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_req(single_req),
        .cont_en(cont_en), .nine_bit(nine_bit), .clk_inv(clk_inv),
        .dat_inv(dat_inv), .wide_div(wide_div), .div_val(div_val),
        .irq_en(irq_en), .rd_data(rd_data), .sdi(sdi), .sck(sck),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .done_flag(done_flag),
        .irq(irq), .ovr_err(ovr_err), .single_busy(single_busy)
    );

    function automatic logic [8:0] tx_word(input int k);
        return 9'(sl_base + k * sl_step);
    endfunction

    assign sck_eff = sck ^ clk_inv;

    // slave: presents the next bit when the clock turns active
    always @(negedge clk) begin
        if (sl_clear) begin
            sl_bit = 0;
            sl_word = 0;
            hi_len = 0;
        end else begin
            if (sck_eff && !sck_prev) begin
                sdi <= tx_word(sl_word)[sl_bit] ^ (sl_comp & dat_inv);
                if (sl_bit == (nine_bit ? 8 : 7)) begin
                    sl_bit = 0;
                    sl_word = sl_word + 1;
                end else begin
                    sl_bit = sl_bit + 1;
                end
                hi_len = 1;
            end else if (sck_eff) begin
                hi_len = hi_len + 1;
            end else if (sck_prev) begin
                last_hi = hi_len;
            end
        end
        sck_prev = sck_eff;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(input logic nine, input logic cinv, input logic dinv,
                         input logic wide, input int div, input int base,
                         input int step, input logic comp);
        @(negedge clk);
        nine_bit = nine; clk_inv = cinv; dat_inv = dinv; wide_div = wide;
        div_val = 16'(div); sl_base = base; sl_step = step; sl_comp = comp;
        sl_clear = 1'b1;
        cycles(2);
        sl_clear = 1'b0;
    endtask

    task automatic wait_done(input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done_flag) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic do_read();
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic pulse_single();
        single_req = 1'b1;
        @(negedge clk);
        single_req = 1'b0;
    endtask

    initial begin
        #(5.0 * 180000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        // reset state
        check("R1 reset sck idle", sck, 0);
        check("R9 reset done", done_flag, 0);
        check("R10 reset ovr", ovr_err, 0);
        check("R9 reset irq", irq, 0);
        check("R4 reset single_busy", single_busy, 0);

        // R1: request pending while port disabled
        setup(0, 0, 0, 0, 0, 8'h3C, 1, 1);
        pulse_single();
        cycles(50);
        check("R1 no clock while disabled", sck, 0);
        check("R1 no word while disabled", done_flag, 0);
        check("R4 request pending", single_busy, 1);
        port_en = 1'b1;
        wait_done(400, ok);
        check("R1 starts once enabled", ok, 1);
        check("R3 data after enable", rx_data, 8'h3C);
        do_read();

        // R2 R3 R4 R8 R9: single words across divider values
        for (int p = 1; p <= 4; p++) begin
            setup(0, 0, 0, 0, p - 1, 8'hA5 ^ (p * 8'h1B), 0, 1);
            irq_en = 1'b0;
            pulse_single();
            wait_done(40 * p + 40, ok);
            check("R4 single completes", ok, 1);
            check("R3 single data", rx_data, (8'hA5 ^ (p * 8'h1B)) & 8'hFF);
            check("R8 bit9 zero in 8-bit", rx_bit9, 0);
            check("R2 active phase length", last_hi, p);
            check("R4 single_busy cleared", single_busy, 0);
            check("R9 irq masked", irq, 0);
            irq_en = 1'b1;
            @(negedge clk);
            check("R9 irq enabled", irq, 1);
            cycles(6 * p);
            check("R4 clock stopped", sck, 0);
            check("R4 one word only", sl_word, 1);
            do_read();
            check("R9 read clears done", done_flag, 0);
            check("R9 irq cleared", irq, 0);
        end
        irq_en = 1'b0;

        // R5: continuous sweep over every byte
        setup(0, 0, 0, 0, 0, 0, 1, 1);
        cont_en = 1'b1;
        for (int k = 0; k < 256; k++) begin
            wait_done(60, ok);
            check("R5 continuous word", ok ? int'(rx_data) : -1, k);
            do_read();
        end
        cont_en = 1'b0;
        @(negedge clk);
        check("R5 abort idles clock", sck, 0);
        cycles(40);
        check("R5 partial word discarded", done_flag, 0);

        // R8: 9-bit continuous
        setup(1, 0, 0, 0, 1, 9'h001, 9'h053, 1);
        cont_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            wait_done(100, ok);
            check("R8 nine-bit word", {23'd0, rx_bit9, rx_data},
                  int'(9'(9'h001 + k * 9'h053)));
            do_read();
        end
        cont_en = 1'b0;
        cycles(40);

        // R7: clock and data inversion
        setup(0, 1, 1, 0, 1, 8'h96, 0, 1);
        cycles(2);
        check("R7 inverted idle high", sck, 1);
        pulse_single();
        wait_done(100, ok);
        check("R7 data with compensated slave", rx_data, 8'h96);
        check("R7 phase length inverted", last_hi, 2);
        cycles(4);
        check("R7 returns to high idle", sck, 1);
        do_read();
        setup(0, 0, 1, 0, 0, 8'h5A, 0, 0);
        pulse_single();
        wait_done(100, ok);
        check("R7 raw data inverted", rx_data, 8'hA5);
        do_read();

        // R6: both enables
        setup(0, 0, 0, 0, 0, 8'h10, 8'h11, 1);
        cont_en = 1'b1;
        pulse_single();
        for (int k = 0; k < 3; k++) begin
            wait_done(60, ok);
            check("R6 continuous wins", ok ? int'(rx_data) : -1, 8'h10 + k * 8'h11);
            if (k == 0) check("R4 single cleared under both", single_busy, 0);
            do_read();
        end
        cont_en = 1'b0;
        cycles(40);

        // R10: overrun
        setup(0, 0, 0, 0, 0, 8'h77, 8'h01, 1);
        cont_en = 1'b1;
        wait_done(60, ok);
        ok = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ovr_err) begin ok = 1'b1; break; end
        end
        check("R10 overrun flagged", ok, 1);
        check("R10 first word kept", rx_data, 8'h77);
        cycles(20);
        check("R10 reception stopped", sck, 0);
        check("R10 no further words", sl_word, 2);
        cont_en = 1'b0;
        @(negedge clk);
        check("R10 cleared by cont fall", ovr_err, 0);
        do_read();

        // R2: divider width select
        setup(0, 0, 0, 0, 16'h0102, 8'hC3, 0, 1);
        pulse_single();
        wait_done(200, ok);
        check("R2 narrow divider", last_hi, 3);
        do_read();
        setup(0, 0, 0, 1, 16'h0102, 8'hC3, 0, 1);
        pulse_single();
        wait_done(6000, ok);
        check("R2 wide divider", last_hi, 259);
        check("R3 data wide divider", rx_data, 8'hC3);
        do_read();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule